// File: doc/BRIEF.md
# Selectable-Order Sinc Decimator

This block turns a one-bit delta-sigma modulator stream into signed 24-bit words at a lower rate. It is a cascaded integrator-comb decimator. A run-time input chooses a third- or fourth-order sinc response. A five-bit index chooses the decimation ratio (OSR) from a fixed set of seventeen values, from 12 up to 160000. Many of these values are not powers of two. Each modulator sample is qualified by a valid strobe, so the modulator may run at half the system clock or slower. The block emits one output word per OSR accepted samples, together with a one-cycle strobe.

The raw comb result grows by order times ceil(log2(OSR)) bits. It is brought to the output width by an arithmetic shift that depends on both settings, and it saturates at full scale instead of wrapping. When the order or ratio input changes, the filter restarts from cleared state. After a restart or a reset, the first few outputs are marked as not yet settled, and the first settled word is flagged on its own.

Top module: `sincsel_decim`

## Requirements
- R1: During and right after reset, `out_valid`, `out_settled` and `out_first` are 0.
- R2: `out_valid` is a single-cycle pulse. After each restart, exactly one pulse follows every OSR accepted modulator samples (samples with `mod_valid`=1).
- R3: `osr_sel` values 0 to 16 select OSR 12, 16, 24, 32, 64, 128, 256, 512, 1024, 2048, 4000, 8000, 16000, 26667, 32000, 96000, 160000 in that order. Values 17 to 31 select 12.
- R4: `order4`=0 gives a third-order response (N=3) and `order4`=1 gives a fourth-order response (N=4).
- R5: Each input bit counts as +1 when 1 and -1 when 0. For a stream whose mean is m, the settled output equals m·OSR^N arithmetically shifted right by N·ceil(log2 OSR) − 23 bits, or shifted left when that count is negative, with floor rounding.
- R6: The output saturates to the range −8388608 to 8388607 and never wraps.
- R7: After a reset or restart, outputs 0 to N−1 have `out_settled`=0 and `out_first`=0. Output N has both set. Later outputs have `out_settled`=1 and `out_first`=0.
- R8: Any change of `order4` or `osr_sel` clears all filter state, the sample count and the settled flag in the next cycle. The sample presented in that cycle is dropped.
- R9: A sample with `mod_valid`=0 is ignored and leaves the integrators and the sample count unchanged.
- R10: `out_valid` goes high one clock cycle after the edge that accepts the last sample of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator output bit |
| mod_valid | input | 1 | Qualifies `mod_bit` for this cycle |
| order4 | input | 1 | 0 selects third order, 1 selects fourth order |
| osr_sel | input | 5 | Decimation ratio index |
| out_data | output | 24 | Signed decimated result |
| out_valid | output | 1 | One-cycle strobe for `out_data` |
| out_settled | output | 1 | Level: the current and later outputs are fully settled |
| out_first | output | 1 | Marks the first settled output after a restart |

## Verification
The assertions check on every cycle that the strobe lasts one cycle and follows a completed window by a fixed delay. They also check that the window counter stays below the selected ratio, that idle samples leave the integrators unchanged, that the first-settled mark comes only with a settled strobe, and that a configuration change drops the settled flag. They also check that the output keeps the sign of the raw comb result, which catches wrap-around. Only the bench's scenarios can show the correct DC values across orders, ratios and densities, and the saturation corners. They also show the mapping of ratio indices, including unused ones, and that strobe spacing counts only accepted samples under random gaps.

// File: rtl/sincsel_pkg.sv
package sincsel_pkg;
  localparam int SEL_W     = 5;
  localparam int RATIO_W   = 18;
  localparam int LOG_MAX   = 18;
  localparam int MAX_ORDER = 4;
  localparam int IN_W      = 2;
  localparam int OUT_W     = 24;
  localparam int ACC_W     = IN_W + MAX_ORDER * LOG_MAX;
  localparam int SH_W      = 8;

  // Ratio selected by index; unused indices fall back to the smallest ratio.
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [SEL_W-1:0] sel);
    case (sel)
      5'd0:  return 18'd12;
      5'd1:  return 18'd16;
      5'd2:  return 18'd24;
      5'd3:  return 18'd32;
      5'd4:  return 18'd64;
      5'd5:  return 18'd128;
      5'd6:  return 18'd256;
      5'd7:  return 18'd512;
      5'd8:  return 18'd1024;
      5'd9:  return 18'd2048;
      5'd10: return 18'd4000;
      5'd11: return 18'd8000;
      5'd12: return 18'd16000;
      5'd13: return 18'd26667;
      5'd14: return 18'd32000;
      5'd15: return 18'd96000;
      5'd16: return 18'd160000;
      default: return 18'd12;
    endcase
  endfunction

  // Bit growth per stage: ceil(log2(ratio)).
  function automatic int ratio_log(input logic [SEL_W-1:0] sel);
    int g;
    logic [RATIO_W:0] r;
    g = 0;
    r = {1'b0, ratio_of(sel)};
    while ((1 << g) < int'(r)) g++;
    return g;
  endfunction

  // Right-shift count that brings the comb result to the output width.
  function automatic logic signed [SH_W-1:0] scale_shift(input logic ord4,
                                                         input logic [SEL_W-1:0] sel);
    int n;
    n = (ord4 ? 4 : 3) * ratio_log(sel) - (OUT_W - 1);
    return SH_W'(n);
  endfunction
endpackage

// File: rtl/sincsel_integ.sv
module sincsel_integ #(
  parameter int W      = 74,
  parameter int STAGES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         en,
  input  logic [W-1:0]                 x,
  output logic [STAGES-1:0][W-1:0]     acc
);
  // Wrap-around running sums; each stage adds the previous stage's register.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (en) begin
      acc[0] <= acc[0] + x;
      for (int s = 1; s < STAGES; s++) acc[s] <= acc[s] + acc[s-1];
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(acc)); // R9
endmodule

// File: rtl/sincsel_comb.sv
module sincsel_comb #(
  parameter int W      = 74,
  parameter int STAGES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         en,
  input  logic [W-1:0]                 din,
  output logic [STAGES-1:0][W-1:0]     y
);
  logic [STAGES-1:0][W-1:0] dly;

  always_comb begin
    y[0] = din - dly[0];
    for (int s = 1; s < STAGES; s++) y[s] = y[s-1] - dly[s];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dly <= '0;
    end else if (en) begin
      dly[0] <= din;
      for (int s = 1; s < STAGES; s++) dly[s] <= y[s-1];
    end
  end
endmodule

// File: rtl/sincsel_scale.sv
module sincsel_scale #(
  parameter int ACC_W = 74,
  parameter int OUT_W = 24,
  parameter int SH_W  = 8
) (
  input  logic signed [ACC_W-1:0] din,
  input  logic signed [SH_W-1:0]  shift,
  output logic signed [OUT_W-1:0] dout
);
  localparam int WIDE = ACC_W + 16;
  localparam logic signed [WIDE-1:0] HI =
    $signed({{(WIDE-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
  localparam logic signed [WIDE-1:0] LO = ~HI;

  logic signed [WIDE-1:0] wide, moved;
  logic signed [SH_W-1:0] neg_sh;

  always_comb begin
    wide   = $signed({{16{din[ACC_W-1]}}, din});
    neg_sh = -shift;
    if (shift >= 0) moved = wide >>> shift[SH_W-2:0];
    else            moved = wide <<< neg_sh[SH_W-2:0];
    if (moved > HI)      dout = HI[OUT_W-1:0];
    else if (moved < LO) dout = LO[OUT_W-1:0];
    else                 dout = moved[OUT_W-1:0];
  end
endmodule

// File: rtl/sincsel_decim.sv
module sincsel_decim #(
  parameter int DATA_W  = sincsel_pkg::OUT_W,
  parameter int ACC_W   = sincsel_pkg::ACC_W,
  parameter int SEL_W   = sincsel_pkg::SEL_W,
  parameter int RATIO_W = sincsel_pkg::RATIO_W,
  parameter int STAGES  = sincsel_pkg::MAX_ORDER
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mod_bit,
  input  logic                     mod_valid,
  input  logic                     order4,
  input  logic [SEL_W-1:0]         osr_sel,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     out_valid,
  output logic                     out_settled,
  output logic                     out_first
);
  localparam int SH_W = sincsel_pkg::SH_W;

  logic                       ord_q;
  logic [SEL_W-1:0]           sel_q;
  logic                       restart, accept, win_done, tick_q;
  logic [RATIO_W-1:0]         osr_cur, cnt;
  logic [ACC_W-1:0]           x_in, comb_in;
  logic signed [ACC_W-1:0]    comb_sel;
  logic [STAGES-1:0][ACC_W-1:0] integ, comb_y;
  logic signed [SH_W-1:0]     sh;
  logic signed [DATA_W-1:0]   scaled;
  logic [2:0]                 ocnt, ord_n;

  // Configuration tracking: any difference restarts the filter.
  assign restart  = (order4 != ord_q) || (osr_sel != sel_q);
  assign accept   = mod_valid && !restart;
  assign osr_cur  = sincsel_pkg::ratio_of(sel_q);
  assign win_done = accept && (cnt == osr_cur - 1'b1);
  assign ord_n    = ord_q ? 3'd4 : 3'd3;
  assign sh       = sincsel_pkg::scale_shift(ord_q, sel_q);
  assign x_in     = mod_bit ? ACC_W'(1) : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ord_q <= order4;
      sel_q <= osr_sel;
    end else if (restart) begin
      ord_q <= order4;
      sel_q <= osr_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= win_done;
      if (accept) cnt <= win_done ? '0 : cnt + 1'b1;
    end
  end

  sincsel_integ #(.W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk(clk), .rst(rst), .clr(restart), .en(accept), .x(x_in), .acc(integ));

  // Order picks the tap: the last integrator and comb stage, or the one before.
  generate
    if (STAGES >= 4) begin : g_tap
      assign comb_in  = ord_q ? integ[3] : integ[2];
      assign comb_sel = $signed(ord_q ? comb_y[3] : comb_y[2]);
    end else begin : g_tap_min
      assign comb_in  = integ[STAGES-1];
      assign comb_sel = $signed(comb_y[STAGES-1]);
    end
  endgenerate

  sincsel_comb #(.W(ACC_W), .STAGES(STAGES)) u_comb (
    .clk(clk), .rst(rst), .clr(restart), .en(tick_q), .din(comb_in), .y(comb_y));

  sincsel_scale #(.ACC_W(ACC_W), .OUT_W(DATA_W), .SH_W(SH_W)) u_scale (
    .din(comb_sel), .shift(sh), .dout(scaled));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      out_data    <= '0;
      out_valid   <= 1'b0;
      out_settled <= 1'b0;
      out_first   <= 1'b0;
      ocnt        <= '0;
    end else begin
      out_valid <= tick_q;
      out_first <= 1'b0;
      if (tick_q) begin
        out_data <= scaled;
        if (ocnt >= ord_n) out_settled <= 1'b1;
        out_first <= (ocnt == ord_n);
        if (ocnt <= ord_n) ocnt <= ocnt + 1'b1;
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < osr_cur); // R2
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(win_done, 2)); // R10
  AST_FIRST_SETTLED: assert property (@(posedge clk) disable iff (rst)
    out_first |-> (out_valid && out_settled)); // R7
  AST_RESTART_UNSETTLE: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!out_settled && !out_valid)); // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_data == '0) || (out_data[DATA_W-1] == $past(comb_sel[ACC_W-1])))); // R6
endmodule

// File: tb/sincsel_decim_test.sv
`timescale 1ns/1ps
module sincsel_decim_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        mod_bit = 1'b0, mod_valid = 1'b0, order4 = 1'b0;
  logic [4:0]  osr_sel = 5'd0;
  logic signed [23:0] out_data;
  logic        out_valid, out_settled, out_first;

  int     checks = 0, errors = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  sincsel_decim uut (
    .clk(clk), .rst(rst), .mod_bit(mod_bit), .mod_valid(mod_valid),
    .order4(order4), .osr_sel(osr_sel), .out_data(out_data),
    .out_valid(out_valid), .out_settled(out_settled), .out_first(out_first));

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int osr_tab(input int sel);
    int t[17] = '{12, 16, 24, 32, 64, 128, 256, 512, 1024, 2048,
                  4000, 8000, 16000, 26667, 32000, 96000, 160000};
    if (sel >= 0 && sel < 17) return t[sel];
    return 12;
  endfunction

  // Expected settled value for a period-4 stream with k ones per period (R5, R6).
  function automatic longint expect_dc(input int ord, input int osr, input int k);
    logic signed [127:0] v;
    int g, sh;
    v = k - 2;
    for (int i = 0; i < ord; i++) v = v * osr;
    v = v / 2;
    g = 0;
    while ((64'd1 << g) < osr) g++;
    sh = ord * g - 23;
    if (sh >= 0) v = v >>> sh;
    else         v = v <<< (-sh);
    if (v > 128'sd8388607)  return 64'sd8388607;
    if (v < -128'sd8388608) return -64'sd8388608;
    return longint'(v);
  endfunction

  task automatic run_case(input int ord, input int sel, input int k, input int gap,
                          input string tag);
    int osr, nout, inwin, pending, phase;
    longint win_cyc, ev;
    bit same, v;
    osr = osr_tab(sel);
    nout = 0; inwin = 0; pending = 0; phase = 0; win_cyc = 0;
    ev = expect_dc(ord, osr, k);
    same = (order4 == (ord == 4)) && (osr_sel == sel[4:0]);
    @(negedge clk);
    mod_valid = 1'b0;
    order4 = (ord == 4);
    osr_sel = sel[4:0];
    if (same) rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!out_settled && !out_valid, "R8 settled cleared after change", out_settled, 0);
    @(negedge clk);
    while (nout < ord + 2 && !done) begin
      v = ($urandom_range(99) >= gap);
      mod_valid = v;
      mod_bit = ((phase % 4) < k);
      @(posedge clk);
      @(negedge clk);
      if (out_valid) begin
        chk(pending == 1, {"R2 strobe per window ", tag}, pending, 1);
        chk(cyc - win_cyc == 1, "R10 strobe latency", cyc - win_cyc, 1);
        pending = 0;
        if (nout < ord) begin
          chk(!out_settled && !out_first, "R7 early output unsettled", out_settled, 0);
        end else if (nout == ord) begin
          chk(out_settled && out_first, "R7 first settled flagged", out_first, 1);
          chk(longint'(out_data) == ev, {"R5 value ", tag}, longint'(out_data), ev);
        end else begin
          chk(out_settled && !out_first, "R7 later output settled only", out_first, 0);
          chk(longint'(out_data) == ev, {"R5 value ", tag}, longint'(out_data), ev);
        end
        nout++;
      end else if (pending == 1 && cyc - win_cyc > 1) begin
        chk(1'b0, "R10 strobe missing", cyc - win_cyc, 1);
        pending = 0;
      end
      if (v) begin
        phase++;
        inwin++;
        if (inwin == osr) begin
          inwin = 0;
          pending++;
          win_cyc = cyc;
        end
      end
    end
    @(negedge clk);
    mod_valid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_settled && !out_first, "R1 outputs low in reset", out_valid, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!out_valid && !out_settled && !out_first, "R1 outputs low after reset", out_valid, 0);

    // Directed corners
    run_case(3, 0, 4, 0, "R4 order3 OSR12 full");
    run_case(4, 0, 3, 0, "R4 order4 OSR12 three quarters");
    run_case(3, 0, 3, 0, "R4 order3 OSR12 three quarters");
    run_case(4, 1, 4, 0, "R6 saturate high");
    run_case(4, 1, 0, 0, "R6 full negative");
    run_case(3, 2, 2, 30, "R9 gapped zero mean");
    run_case(4, 6, 1, 50, "R9 gapped quarter");
    run_case(3, 25, 1, 0, "R3 unused index");
    run_case(3, 10, 3, 0, "R3 OSR4000");
    run_case(3, 10, 3, 0, "R8 same config via reset");
    // Constrained random
    for (int i = 0; i < 14 && !done; i++) begin
      int ord, sel, k, gap;
      ord = ($urandom_range(1) == 0) ? 3 : 4;
      sel = $urandom_range(7);
      k   = $urandom_range(4);
      gap = ($urandom_range(1) == 0) ? 0 : 40;
      run_case(ord, sel, k, gap, "R5 random");
    end
    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end
endmodule